// File: doc/BRIEF.md
# Asynchronous ROM Read Sequencer

This block lets a clocked host read bytes from a bank of external asynchronous ROM devices that share one address bus, one data bus and one active-low output-enable line. Each device has its own active-low chip enable. The host presents a byte address and a bank number and raises `req` while `ready` is high. The sequencer then drives the address and the selected chip enable. After a programmable number of clocks it lowers the shared output enable. It holds that enable for a second programmable count and captures the data bus on the clock edge that ends the enable window. The byte is returned with a single-cycle `rvalid`.

The three wait counts come from the device's address, chip-enable and output-enable access times and from the bus float time, converted to clocks by the integrator. They are sampled when a request is accepted. A read that stays on the device already selected keeps that chip enable low and adds no extra cycles. A read that moves to another device first releases every chip enable for a turnaround gap, so that the previous device's outputs have floated before the new one can drive. The very first read after reset has no previous driver and takes no gap.

Top module: `rom_read_seq`

## Requirements
- R1: During and after reset, every `rom_ce_n` bit and `rom_oe_n` are 1, `rom_addr` is 0, `ready` is 1 and `rvalid` is 0.
- R2: Bank number b selects device b: while `rom_oe_n` is 0, `rom_ce_n` equals the vector with only bit b at 0. At no time is more than one `rom_ce_n` bit at 0.
- R3: `rom_oe_n` is 0 only while a chip enable is 0. Each read holds `rom_oe_n` at 0 for exactly `cfg_oe_smp`+1 consecutive cycles.
- R4: Counting clock edges from the accepting edge (edge 0), `rom_oe_n` falls at edge g+`cfg_addr_oe`. Here g is the turnaround gap applied to that read (see R8 and R9).
- R5: `rdata` takes the value on `rom_dq` at the clock edge that raises `rom_oe_n` again, and `rvalid` is 1 for exactly one cycle after that edge.
- R6: `rvalid` rises at edge g+`cfg_addr_oe`+`cfg_oe_smp`+1 after the accepting edge.
- R7: A read to the device selected by the previous read keeps that chip enable at 0 throughout, including while idle between the reads, and applies g=0.
- R8: A read to a different device, after an earlier read, applies g=`cfg_gap`. All `rom_ce_n` bits are 1 for the first g cycles, and `rom_oe_n` has been 1 for at least g cycles before it falls.
- R9: The first read after reset applies g=0, and its chip enable falls at the accepting edge.
- R10: `ready` is 1 only while idle, and then `rom_oe_n` is 1. A `req` raised while `ready` is 0 is ignored and produces no `rvalid`.
- R11: `rom_addr` takes the request address at the accepting edge and holds it until the next accepted request, and so holds it through the output-enable window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, taken when `ready` is 1 |
| req_bank | input | BANK_W | Device number for the read |
| req_addr | input | ADDR_W | Byte address for the read |
| cfg_addr_oe | input | 4 | Cycles from address/chip enable to output enable |
| cfg_oe_smp | input | 4 | Extra cycles the output enable is held before sampling |
| cfg_gap | input | 4 | Turnaround cycles when the device changes |
| ready | output | 1 | Idle, able to accept a request |
| rdata | output | DATA_W | Captured byte |
| rvalid | output | 1 | One-cycle pulse, `rdata` is valid |
| rom_addr | output | ADDR_W | Address bus to the ROM devices |
| rom_ce_n | output | 2**BANK_W | Active-low chip enable, one per device |
| rom_oe_n | output | 1 | Shared active-low output enable |
| rom_dq | input | DATA_W | ROM data bus |

## Verification
A phase register stuck in the wrong state or a miscounted timer shows up during the same read. The output-enable window opens on the wrong edge or has the wrong length, and `rvalid` lands off its computed edge. A wrong device register drives the wrong chip enable in the first cycle of the access, so the returned byte differs from the bank's pattern. A lost record of the current device appears at the next read, either as a missing turnaround gap after a device change or as a chip-enable release between two reads of one device.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;

  parameter int CNT_W = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GAP  = 2'd1,
    PH_ADDR = 2'd2,
    PH_OE   = 2'd3
  } phase_e;

  typedef struct packed {
    phase_e ph;
    cnt_t   cnt;
  } step_t;

  // Phase after the address set-up: the enable window lasts s+1 cycles.
  function automatic step_t after_addr(input cnt_t s);
    step_t r;
    r.ph  = PH_OE;
    r.cnt = s;
    return r;
  endfunction

  // Phase after the turnaround gap: set-up is skipped when its count is zero.
  function automatic step_t after_gap(input cnt_t a, input cnt_t s);
    step_t r;
    if (a != '0) begin
      r.ph  = PH_ADDR;
      r.cnt = a - cnt_t'(1);
    end else begin
      r = after_addr(s);
    end
    return r;
  endfunction

  // First phase of an accepted read: counts checked as gap, set-up, window.
  function automatic step_t on_accept(input logic gap_on, input cnt_t g,
                                      input cnt_t a, input cnt_t s);
    step_t r;
    if (gap_on && (g != '0)) begin
      r.ph  = PH_GAP;
      r.cnt = g - cnt_t'(1);
    end else begin
      r = after_gap(a, s);
    end
    return r;
  endfunction

endpackage

// File: rtl/rom_ce_decode.sv
module rom_ce_decode #(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic [BANK_W-1:0] sel,
  input  logic              en,
  output logic [NBANK-1:0]  ce_n
);

  for (genvar b = 0; b < NBANK; b++) begin : g_ce
    assign ce_n[b] = !(en && (sel == BANK_W'(b)));
  end

endmodule

// File: rtl/rom_wait_timer.sv
module rom_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rom_data_capture.sv
module rom_data_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= strobe;
      if (strobe) rdata <= dq;
    end
  end

  // R5: a captured byte is announced for a single cycle only
  p_rvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: rtl/rom_read_seq.sv
module rom_read_seq
  import rom_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  cfg_addr_oe,
  input  logic [CNT_W-1:0]  cfg_oe_smp,
  input  logic [CNT_W-1:0]  cfg_gap,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [NBANK-1:0]  rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_dq
);

  phase_e            phase_q;
  step_t             step_nx;
  logic              t_load;
  logic              t_zero;
  logic [BANK_W-1:0] bank_q;
  logic              ce_act_q;
  logic [ADDR_W-1:0] addr_q;
  cnt_t              a_q, s_q, g_q;

  // Named events for the assertions and for reading the code.
  logic accept_evt;
  logic switch_dev;
  logic gap_done;
  logic sample_evt;

  assign ready      = (phase_q == PH_IDLE);
  assign accept_evt = req && ready;
  assign switch_dev = ce_act_q && (req_bank != bank_q);
  assign gap_done   = (phase_q == PH_GAP) && t_zero;
  assign sample_evt = (phase_q == PH_OE) && t_zero;

  always_comb begin
    t_load  = 1'b0;
    step_nx = '{ph: phase_q, cnt: '0};
    case (phase_q)
      PH_IDLE: if (accept_evt) begin
        t_load  = 1'b1;
        step_nx = on_accept(switch_dev, cfg_gap, cfg_addr_oe, cfg_oe_smp);
      end
      PH_GAP: if (t_zero) begin
        t_load  = 1'b1;
        step_nx = after_gap(a_q, s_q);
      end
      PH_ADDR: if (t_zero) begin
        t_load  = 1'b1;
        step_nx = after_addr(s_q);
      end
      PH_OE: if (t_zero) begin
        step_nx.ph = PH_IDLE;
      end
      default: step_nx.ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bank_q   <= '0;
      ce_act_q <= 1'b0;
      addr_q   <= '0;
      a_q      <= '0;
      s_q      <= '0;
      g_q      <= '0;
    end else begin
      phase_q <= step_nx.ph;
      if (accept_evt) begin
        bank_q   <= req_bank;
        addr_q   <= req_addr;
        a_q      <= cfg_addr_oe;
        s_q      <= cfg_oe_smp;
        g_q      <= cfg_gap;
        ce_act_q <= (step_nx.ph != PH_GAP);
      end else if (gap_done) begin
        ce_act_q <= 1'b1;
      end
    end
  end

  rom_wait_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (step_nx.cnt),
    .zero     (t_zero)
  );

  rom_ce_decode #(.BANK_W(BANK_W)) u_dec (
    .sel  (bank_q),
    .en   (ce_act_q),
    .ce_n (rom_ce_n)
  );

  rom_data_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (sample_evt),
    .dq     (rom_dq),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  assign rom_addr = addr_q;
  assign rom_oe_n = (phase_q != PH_OE);

  // Checker state: cycles the output enable has been high, and whether the
  // current read moved to another device.
  cnt_t float_cnt;
  logic sw_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      float_cnt <= '1;
      sw_pend   <= 1'b0;
    end else begin
      if (!rom_oe_n)          float_cnt <= '0;
      else if (float_cnt != '1) float_cnt <= float_cnt + cnt_t'(1);
      if (accept_evt) sw_pend <= switch_dev;
    end
  end

  // R2: never two devices selected at once
  p_ce_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~rom_ce_n));

  // R3: the shared enable is only low with a device selected
  p_oe_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (~rom_ce_n != '0));

  // R8: after a device change the bus had floated for the gap
  p_float_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rom_oe_n) && sw_pend) |-> (float_cnt >= g_q));

  // R10: idle means the enable is released
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> rom_oe_n);

  // R11: the address does not move inside the enable window
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_oe_n && !$past(rom_oe_n)) |-> $stable(rom_addr));

endmodule

// File: tb/tb_rom_read_seq.sv
module tb_rom_read_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  bank = '0;
  logic [12:0] addr = '0;
  logic [3:0]  cfg_a = '0, cfg_s = '0, cfg_g = '0;
  logic        ready, rvalid, rom_oe_n;
  logic [7:0]  rdata, rom_dq;
  logic [12:0] rom_addr;
  logic [3:0]  rom_ce_n;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rom_read_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_bank(bank), .req_addr(addr),
    .cfg_addr_oe(cfg_a), .cfg_oe_smp(cfg_s), .cfg_gap(cfg_g),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .rom_addr(rom_addr),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_dq(rom_dq)
  );

  function automatic logic [7:0] pat(input logic [1:0] b, input logic [12:0] a);
    return (a[7:0] ^ {a[12:8], 1'b1, b}) + 8'h31;
  endfunction

  // ROM bank model: a device drives only with its chip enable and the shared enable low.
  always_comb begin
    rom_dq = 8'h5A;
    for (int b = 0; b < 4; b++)
      if (!rom_oe_n && rom_ce_n == ~(4'b0001 << b)) rom_dq = pat(2'(b), rom_addr);
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One read; g is the gap the requirements predict for it.
  task automatic do_read(input logic [1:0] b, input logic [12:0] ad,
                         input int a, input int s, input int gc, input int g,
                         input bit poke, input string tag);
    int first_oe = -1, oe_cnt = 0, ah_cnt = 0, bad_ce = 0;
    int rv_idx = -1, rv_cnt = 0, data = 0, busy_rdy = 0;
    cfg_a = 4'(a); cfg_s = 4'(s); cfg_g = 4'(gc);
    while (!ready) @(negedge clk);
    bank = b; addr = ad; req = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      if (i > 0) @(negedge clk);
      if (poke) begin
        req  = (i == 1 || i == 2);
        addr = ad ^ 13'h0F0;
        if (i == 1) busy_rdy = ready;
      end else begin
        req = 1'b0;
      end
      if (first_oe < 0 && &rom_ce_n) ah_cnt++;
      if (!rom_oe_n) begin
        if (first_oe < 0) first_oe = i;
        oe_cnt++;
        if (rom_ce_n != ~(4'b0001 << b)) bad_ce++;
      end
      if (rvalid) begin
        rv_cnt++;
        if (rv_idx < 0) begin rv_idx = i; data = rdata; end
      end
      if (rv_idx >= 0 && i > rv_idx + 2) break;
    end
    req = 1'b0;
    chk({tag, " R6 latency"}, rv_idx, g + a + s + 1);
    chk({tag, " R4 oe fall edge"}, first_oe, g + a);
    chk({tag, " R3 oe window"}, oe_cnt, s + 1);
    chk({tag, " R2 ce select"}, bad_ce, 0);
    chk({tag, " R5 data"}, data, pat(b, ad));
    chk({tag, " R5 rvalid pulses"}, rv_cnt, 1);
    chk({tag, " R8 R9 gap cycles"}, ah_cnt, g);
    chk({tag, " R11 address held"}, rom_addr, ad);
    if (poke) chk({tag, " R10 ready low while busy"}, busy_rdy, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ce_n", rom_ce_n, 4'hF);
    chk("R1 oe_n", rom_oe_n, 1);
    chk("R1 addr", rom_addr, 0);
    chk("R1 ready", ready, 1);
    chk("R1 rvalid", rvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ce_n after release", rom_ce_n, 4'hF);
  endtask

  task automatic t_first;
    do_read(2'd2, 13'h1A3C, 3, 2, 4, 0, 0, "R9 first read");
  endtask

  task automatic t_same;
    do_read(2'd2, 13'h0456, 2, 1, 7, 0, 0, "R7 same device");
    chk("R7 ce held while idle", rom_ce_n[2], 0);
    chk("R7 oe released idle", rom_oe_n, 1);
    do_read(2'd2, 13'h1FFF, 0, 0, 7, 0, 0, "R7 zero counts");
  endtask

  task automatic t_switch;
    do_read(2'd1, 13'h0001, 1, 1, 4, 4, 0, "R8 switch");
    do_read(2'd3, 13'h0BEE, 15, 15, 15, 15, 0, "R8 max counts");
    do_read(2'd0, 13'h0000, 2, 0, 0, 0, 0, "R8 zero gap");
  endtask

  task automatic t_busy;
    do_read(2'd0, 13'h0777, 6, 3, 2, 0, 1, "R10 busy req");
  endtask

  task automatic t_decode;
    for (int b = 1; b < 4; b++)
      do_read(2'(b), 13'(b * 13'h0531), 1, 2, 1, 1, 0, "R2 decode");
  endtask

  initial begin
    t_reset();
    t_first();
    t_same();
    t_switch();
    t_busy();
    t_decode();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule